// File: doc/BRIEF.md
# Video Register File with Boot Gating

This block holds the processor-facing registers of a tile-based video engine and reproduces how they come up. It stores the control and mask bytes, a 16-bit scroll pair, a 16-bit video memory address, an 8-bit sprite pointer, a read-ahead buffer for the data port, and the one toggle shared by the scroll and address ports. Three start events are told apart. A cold power-on clears everything. A warm reset clears only part of the state. A power-on after a brief outage acts like a warm reset, except that the vertical-blank flag starts set and the address starts at 0x0001.

After any start event a warm-up counter runs. Until it expires, writes to the control, mask, scroll and address ports are discarded. Status, sprite pointer, sprite data, the data port and sprite DMA work from the first cycle. A second counter raises the vertical-blank status bit at a fixed count after the event and then once per frame. A single parameter picks NTSC or PAL constants. Video memory and sprite memory sit outside the block and are reached through write strobes and a read-data input.

Top module: `vidreg_bootctl`

## Requirements
- R1: A cold power-on (`pwr_on`=1, `pwr_brief`=0) clears control, mask, scroll, address and sprite pointer to zero. It also clears the write toggle and the vertical-blank flag.
- R2: A warm reset (`rst`=1 while `pwr_on`=0) clears control, scroll and the toggle. It clears mask bits 7:3 and 0 and keeps mask bits 2:1. It zeroes the read buffer. It leaves the sprite pointer, the address and the vertical-blank flag unchanged.
- R3: A power-on with `pwr_brief`=1 acts as R2, except that the vertical-blank flag becomes 1 and the address becomes 0x0001.
- R4: Call the event edge 0. Writes to offsets 0 (control), 1 (mask), 5 (scroll) and 6 (address) that are sampled at edge k are dropped for k < WARM_CLKS and accepted for k >= WARM_CLKS. WARM_CLKS is 29658 for NTSC and 33132 for PAL. A dropped write leaves the toggle unchanged.
- R5: Offsets 2, 3, 4 and 7, and the DMA input, act from edge 1 after any event.
- R6: The vertical-blank flag is set at edge VBL_FIRST after the event (27384 for NTSC) and again every VBL_PERIOD edges after that (29781 for NTSC).
- R7: A read of offset 2 returns the flag in bit 7 and zeros in bits 6:0. The read clears the flag and the toggle. If the flag is set on the same edge as the read, it stays set and the read returns bit 7 = 0.
- R8: A write to offset 5 with the toggle clear loads scroll bits 7:0. With the toggle set it loads bits 15:8. Each accepted write flips the toggle.
- R9: A write to offset 6 with the toggle clear loads address bits 15:8. With the toggle set it loads bits 7:0. Each accepted write flips the toggle.
- R10: A write to offset 7 pulses `vram_we` for one cycle, with the address as it was before the write. A read of offset 7 returns the buffer and then loads `vram_q` into the buffer. Both advance the address by 32 when control bit 2 is 1, and by 1 when it is 0.
- R11: A write to offset 3 sets the sprite pointer. A write to offset 4, or a DMA strobe, pulses `spr_we` at the pointer and then increments it. DMA wins over an offset-4 or offset-3 write in the same cycle. Reads of offsets other than 2 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| pwr_on | input | 1 | Power-on strobe |
| pwr_brief | input | 1 | Qualifies `pwr_on`: power was off only briefly |
| rst | input | 1 | Warm reset strobe |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wd | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| vram_q | input | 8 | Video memory data at `vaddr_o` |
| vram_we | output | 1 | Video memory write pulse |
| vram_wa | output | 16 | Video memory write address |
| vram_wd | output | 8 | Video memory write data |
| dma_we | input | 1 | Sprite DMA byte strobe |
| dma_wd | input | 8 | Sprite DMA byte |
| spr_we | output | 1 | Sprite memory write pulse |
| spr_wa | output | 8 | Sprite memory write address |
| spr_wd | output | 8 | Sprite memory write data |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| scroll_o | output | 16 | Scroll pair |
| vaddr_o | output | 16 | Video memory address |
| spr_addr_o | output | 8 | Sprite pointer |
| vblank_o | output | 1 | Vertical-blank status flag |

## Verification
The hardest cases to reach are the edges of the warm-up window and a status read that lands on the same edge as a vertical-blank set. Both lie tens of thousands of cycles after a start event. The bench counts edges from the event and idles until it is one edge short of each boundary. It then places single directed accesses on edges WARM_CLKS-1 and WARM_CLKS, and on the edge where the second vertical-blank set falls. Seeded random register traffic runs inside and just after the window. Before the warm reset, the registers are driven into a known non-zero state so that the reset's keep/clear split shows at the ports.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_MASK = 3'd1,
    OFS_STAT = 3'd2,
    OFS_SPRA = 3'd3,
    OFS_SPRD = 3'd4,
    OFS_SCRL = 3'd5,
    OFS_ADDR = 3'd6,
    OFS_DATA = 3'd7
  } reg_ofs_e;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_COLD    = 2'd1,
    EV_WARMPWR = 2'd2,
    EV_RESET   = 2'd3
  } boot_ev_e;

  // Writes to these offsets wait for the warm-up window.
  function automatic logic is_gated(input reg_ofs_e o);
    return (o == OFS_CTRL) || (o == OFS_MASK) ||
           (o == OFS_SCRL) || (o == OFS_ADDR);
  endfunction

  // Window length: nine clocks short of the pre-render line count.
  function automatic int warm_clks(input bit pal);
    return pal ? 33132 : 29658;
  endfunction

  function automatic int vbl_first(input bit pal);
    return pal ? 25681 : 27384;
  endfunction

  function automatic int vbl_period(input bit pal);
    return pal ? 33248 : 29781;
  endfunction

endpackage

// File: rtl/vidreg_warmup.sv
module vidreg_warmup
  import vidreg_pkg::*;
#(
  parameter int WARM_CLKS = 29658
) (
  input  logic     clk,
  input  boot_ev_e ev,
  output logic     gate_open
);

  localparam int CW = $clog2(WARM_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic          open_q;

  // Counter stops once the window has closed.
  always_ff @(posedge clk) begin
    if (ev != EV_NONE) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (!open_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(WARM_CLKS - 2)) open_q <= 1'b1;
    end
  end

  assign gate_open = open_q;

  initial begin
    assert (WARM_CLKS >= 2) else $error("window too short");
  end

  // R4
  gate_shut_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev != EV_NONE) |=> !gate_open);

  // R4
  gate_sticky_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (gate_open && ev == EV_NONE) |=> gate_open);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_NONE) |=> (cnt_q <= CW'(WARM_CLKS - 1)));

endmodule

// File: rtl/vidreg_vbl.sv
module vidreg_vbl
  import vidreg_pkg::*;
#(
  parameter int VBL_FIRST  = 27384,
  parameter int VBL_PERIOD = 29781
) (
  input  logic     clk,
  input  boot_ev_e ev,
  input  logic     stat_rd,
  output logic     vbl_o
);

  localparam int MAXC = (VBL_FIRST > VBL_PERIOD) ? VBL_FIRST : VBL_PERIOD;
  localparam int PW   = $clog2(MAXC + 1);

  logic [PW-1:0] ph_q;
  logic          first_q;
  logic          vbl_q;
  logic          set_now;

  always_comb begin
    if (first_q) set_now = (ph_q == PW'(VBL_FIRST - 1));
    else         set_now = (ph_q == PW'(VBL_PERIOD - 1));
  end

  always_ff @(posedge clk) begin
    case (ev)
      EV_COLD: begin
        ph_q    <= '0;
        first_q <= 1'b1;
        vbl_q   <= 1'b0;
      end
      EV_WARMPWR: begin
        ph_q    <= '0;
        first_q <= 1'b1;
        vbl_q   <= 1'b1;
      end
      EV_RESET: begin
        ph_q    <= '0;
        first_q <= 1'b1;
      end
      default: begin
        if (set_now) begin
          ph_q    <= '0;
          first_q <= 1'b0;
          vbl_q   <= 1'b1;
        end else begin
          ph_q <= ph_q + PW'(1);
          if (stat_rd) vbl_q <= 1'b0;
        end
      end
    endcase
  end

  assign vbl_o = vbl_q;

  // R2
  vbl_keep_rst_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_RESET) |=> (vbl_o == $past(vbl_o)));

  // R3
  vbl_brief_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_WARMPWR) |=> vbl_o);

  // R7
  vbl_rdclr_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (stat_rd && !set_now && ev == EV_NONE) |=> !vbl_o);

  // R6
  vbl_set_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (set_now && ev == EV_NONE) |=> vbl_o);

endmodule

// File: rtl/vidreg_file.sv
module vidreg_file
  import vidreg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SAW        = 8,
  parameter int INC_BIT    = 2,
  parameter int ROW_STRIDE = 32,
  parameter logic [DW-1:0] MASK_KEEP = 8'h06
) (
  input  logic            clk,
  input  boot_ev_e        ev,
  input  logic            gate_open,
  input  logic [2:0]      sel,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   wd,
  input  logic [DW-1:0]   vram_q,
  input  logic            dma_we,
  input  logic [DW-1:0]   dma_wd,
  input  logic            vbl,
  output logic            stat_rd,
  output logic [DW-1:0]   rdata,
  output logic            vram_we,
  output logic [2*DW-1:0] vram_wa,
  output logic [DW-1:0]   vram_wd,
  output logic            spr_we,
  output logic [SAW-1:0]  spr_wa,
  output logic [DW-1:0]   spr_wd,
  output logic [DW-1:0]   ctrl,
  output logic [DW-1:0]   mask,
  output logic [2*DW-1:0] scroll,
  output logic [2*DW-1:0] vaddr,
  output logic [SAW-1:0]  spr_addr
);

  localparam int AW = 2 * DW;

  reg_ofs_e        sel_e;
  logic            wr_ok;
  logic [AW-1:0]   step;

  logic [DW-1:0]   ctrl_q, mask_q, rbuf_q, rdata_q, vram_wd_q, spr_wd_q;
  logic [AW-1:0]   scroll_q, vaddr_q, vram_wa_q;
  logic [SAW-1:0]  spra_q, spr_wa_q;
  logic            tog_q, vram_we_q, spr_we_q;

  assign sel_e   = reg_ofs_e'(sel);
  assign wr_ok   = wr && (!is_gated(sel_e) || gate_open);
  assign step    = ctrl_q[INC_BIT] ? AW'(ROW_STRIDE) : AW'(1);
  assign stat_rd = (ev == EV_NONE) && rd && !wr && (sel_e == OFS_STAT);

  always_ff @(posedge clk) begin
    vram_we_q <= 1'b0;
    spr_we_q  <= 1'b0;
    case (ev)
      EV_COLD: begin
        ctrl_q   <= '0;
        mask_q   <= '0;
        scroll_q <= '0;
        vaddr_q  <= '0;
        spra_q   <= '0;
        tog_q    <= 1'b0;
        rdata_q  <= '0;
      end
      EV_WARMPWR, EV_RESET: begin
        ctrl_q   <= '0;
        mask_q   <= mask_q & MASK_KEEP;
        scroll_q <= '0;
        tog_q    <= 1'b0;
        rbuf_q   <= '0;
        if (ev == EV_WARMPWR) vaddr_q <= AW'(1);
      end
      default: begin
        if (dma_we) begin
          spr_we_q <= 1'b1;
          spr_wa_q <= spra_q;
          spr_wd_q <= dma_wd;
          spra_q   <= spra_q + SAW'(1);
        end
        if (wr_ok) begin
          case (sel_e)
            OFS_CTRL: ctrl_q <= wd;
            OFS_MASK: mask_q <= wd;
            OFS_SPRA: if (!dma_we) spra_q <= wd[SAW-1:0];
            OFS_SPRD: begin
              if (!dma_we) begin
                spr_we_q <= 1'b1;
                spr_wa_q <= spra_q;
                spr_wd_q <= wd;
                spra_q   <= spra_q + SAW'(1);
              end
            end
            OFS_SCRL: begin
              if (tog_q) scroll_q[AW-1:DW] <= wd;
              else       scroll_q[DW-1:0]  <= wd;
              tog_q <= ~tog_q;
            end
            OFS_ADDR: begin
              if (tog_q) vaddr_q[DW-1:0]  <= wd;
              else       vaddr_q[AW-1:DW] <= wd;
              tog_q <= ~tog_q;
            end
            OFS_DATA: begin
              vram_we_q <= 1'b1;
              vram_wa_q <= vaddr_q;
              vram_wd_q <= wd;
              vaddr_q   <= vaddr_q + step;
            end
            default: ;
          endcase
        end else if (rd && !wr) begin
          case (sel_e)
            OFS_STAT: begin
              rdata_q <= {vbl, {(DW-1){1'b0}}};
              tog_q   <= 1'b0;
            end
            OFS_DATA: begin
              rdata_q <= rbuf_q;
              rbuf_q  <= vram_q;
              vaddr_q <= vaddr_q + step;
            end
            default: rdata_q <= '0;
          endcase
        end
      end
    endcase
  end

  assign rdata    = rdata_q;
  assign vram_we  = vram_we_q;
  assign vram_wa  = vram_wa_q;
  assign vram_wd  = vram_wd_q;
  assign spr_we   = spr_we_q;
  assign spr_wa   = spr_wa_q;
  assign spr_wd   = spr_wd_q;
  assign ctrl     = ctrl_q;
  assign mask     = mask_q;
  assign scroll   = scroll_q;
  assign vaddr    = vaddr_q;
  assign spr_addr = spra_q;

  // R4
  ctrl_gated_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_NONE && wr && sel == 3'd0 && !gate_open) |=> $stable(ctrl));

  // R2
  keep_on_rst_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_RESET) |=> ($stable(spr_addr) && $stable(vaddr) && ctrl == '0));

  // R7
  tog_clear_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    stat_rd |=> !tog_q);

  // R10
  vram_pulse_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_NONE && wr && sel == 3'd7) |=> (vram_we && vram_wa == $past(vaddr)));

  // R11
  dma_pulse_chk: assert property (@(posedge clk) disable iff (ev == EV_COLD)
    (ev == EV_NONE && dma_we) |=> (spr_we && spr_wd == $past(dma_wd)));

endmodule

// File: rtl/vidreg_bootctl.sv
module vidreg_bootctl
  import vidreg_pkg::*;
#(
  parameter bit PAL_MODE   = 1'b0,
  parameter int DW         = 8,
  parameter int SAW        = 8,
  parameter int INC_BIT    = 2,
  parameter int ROW_STRIDE = 32,
  parameter int WARM_CLKS  = warm_clks(PAL_MODE),
  parameter int VBL_FIRST  = vbl_first(PAL_MODE),
  parameter int VBL_PERIOD = vbl_period(PAL_MODE)
) (
  input  logic            clk,
  input  logic            pwr_on,
  input  logic            pwr_brief,
  input  logic            rst,
  input  logic [2:0]      reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wd,
  output logic [DW-1:0]   reg_rdata,
  input  logic [DW-1:0]   vram_q,
  output logic            vram_we,
  output logic [2*DW-1:0] vram_wa,
  output logic [DW-1:0]   vram_wd,
  input  logic            dma_we,
  input  logic [DW-1:0]   dma_wd,
  output logic            spr_we,
  output logic [SAW-1:0]  spr_wa,
  output logic [DW-1:0]   spr_wd,
  output logic [DW-1:0]   ctrl_o,
  output logic [DW-1:0]   mask_o,
  output logic [2*DW-1:0] scroll_o,
  output logic [2*DW-1:0] vaddr_o,
  output logic [SAW-1:0]  spr_addr_o,
  output logic            vblank_o
);

  boot_ev_e ev;
  logic     gate_open;
  logic     stat_rd;
  logic     vbl;

  // Power-on outranks warm reset.
  always_comb begin
    ev = EV_NONE;
    if (pwr_on)   ev = pwr_brief ? EV_WARMPWR : EV_COLD;
    else if (rst) ev = EV_RESET;
  end

  vidreg_warmup #(.WARM_CLKS(WARM_CLKS)) warm_i (
    .clk(clk), .ev(ev), .gate_open(gate_open)
  );

  vidreg_vbl #(.VBL_FIRST(VBL_FIRST), .VBL_PERIOD(VBL_PERIOD)) vbl_i (
    .clk(clk), .ev(ev), .stat_rd(stat_rd), .vbl_o(vbl)
  );

  vidreg_file #(
    .DW(DW), .SAW(SAW), .INC_BIT(INC_BIT), .ROW_STRIDE(ROW_STRIDE)
  ) file_i (
    .clk(clk), .ev(ev), .gate_open(gate_open),
    .sel(reg_sel), .wr(reg_wr), .rd(reg_rd), .wd(reg_wd),
    .vram_q(vram_q), .dma_we(dma_we), .dma_wd(dma_wd), .vbl(vbl),
    .stat_rd(stat_rd), .rdata(reg_rdata),
    .vram_we(vram_we), .vram_wa(vram_wa), .vram_wd(vram_wd),
    .spr_we(spr_we), .spr_wa(spr_wa), .spr_wd(spr_wd),
    .ctrl(ctrl_o), .mask(mask_o), .scroll(scroll_o),
    .vaddr(vaddr_o), .spr_addr(spr_addr_o)
  );

  assign vblank_o = vbl;

endmodule

// File: tb/vidreg_bootctl_tb.sv
`timescale 1ns/1ps
module vidreg_bootctl_tb_top;

  localparam int WARM = 29658;
  localparam int VF   = 27384;
  localparam int VP   = 29781;

  logic clk = 1'b0;
  logic pwr_on = 1'b1, pwr_brief = 1'b0, rst = 1'b0;
  logic [2:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, dma_we = 1'b0;
  logic [7:0] reg_wd = '0, vram_q = '0, dma_wd = '0;
  logic [7:0] reg_rdata, vram_wd, spr_wa, spr_wd, ctrl_o, mask_o, spr_addr_o;
  logic [15:0] vram_wa, scroll_o, vaddr_o;
  logic vram_we, spr_we, vblank_o;

  always #2 clk = ~clk;

  vidreg_bootctl dut_i (
    .clk(clk), .pwr_on(pwr_on), .pwr_brief(pwr_brief), .rst(rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wd(reg_wd),
    .reg_rdata(reg_rdata), .vram_q(vram_q), .vram_we(vram_we),
    .vram_wa(vram_wa), .vram_wd(vram_wd), .dma_we(dma_we), .dma_wd(dma_wd),
    .spr_we(spr_we), .spr_wa(spr_wa), .spr_wd(spr_wd), .ctrl_o(ctrl_o),
    .mask_o(mask_o), .scroll_o(scroll_o), .vaddr_o(vaddr_o),
    .spr_addr_o(spr_addr_o), .vblank_o(vblank_o)
  );

  int n_tests = 0, n_fail = 0, k = 0;
  logic [7:0]  m_ctrl, m_mask, m_spra, m_buf;
  logic [15:0] m_scroll, m_vaddr;
  logic        m_tog, m_vbl;

  function automatic bit vbl_due(input int c);
    return (c == VF) || (c > VF && ((c - VF) % VP) == 0);
  endfunction

  function automatic logic [15:0] step_of(input logic [7:0] c);
    return c[2] ? 16'd32 : 16'd1;
  endfunction

  function automatic bit gated(input logic [2:0] s);
    return s == 3'd0 || s == 3'd1 || s == 3'd5 || s == 3'd6;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    k++;
    if (vbl_due(k)) m_vbl = 1'b1;
  endtask

  task automatic idle_to(input int target);
    while (k < target) tick();
  endtask

  task automatic chk_state(input string tag);
    chk(tag, {7'd0, vblank_o, ctrl_o, mask_o, scroll_o, vaddr_o, spr_addr_o},
             {7'd0, m_vbl, m_ctrl, m_mask, m_scroll, m_vaddr, m_spra});
  endtask

  task automatic boot(input bit pw, input bit brief, input bit rs);
    pwr_on = pw; pwr_brief = brief; rst = rs;
    @(posedge clk); #1;
    pwr_on = 1'b0; pwr_brief = 1'b0; rst = 1'b0;
    k = 0;
    if (pw && !brief) begin
      m_ctrl = 0; m_mask = 0; m_scroll = 0; m_vaddr = 0; m_spra = 0;
      m_tog = 0; m_vbl = 0;
    end else begin
      m_ctrl = 0; m_mask = m_mask & 8'h06; m_scroll = 0; m_tog = 0; m_buf = 0;
      if (pw) begin m_vbl = 1'b1; m_vaddr = 16'h0001; end
    end
  endtask

  task automatic do_wr(input logic [2:0] s, input logic [7:0] d, input string tag);
    logic [15:0] wa;
    logic [7:0]  sa;
    bit ok;
    ok = !gated(s) || (k + 1 >= WARM);
    wa = m_vaddr; sa = m_spra;
    reg_sel = s; reg_wd = d; reg_wr = 1'b1;
    if (ok) begin
      case (s)
        3'd0: m_ctrl = d;
        3'd1: m_mask = d;
        3'd3: m_spra = d;
        3'd4: m_spra = m_spra + 8'd1;
        3'd5: begin
          if (m_tog) m_scroll[15:8] = d; else m_scroll[7:0] = d;
          m_tog = ~m_tog;
        end
        3'd6: begin
          if (m_tog) m_vaddr[7:0] = d; else m_vaddr[15:8] = d;
          m_tog = ~m_tog;
        end
        3'd7: m_vaddr = m_vaddr + step_of(m_ctrl);
        default: ;
      endcase
    end
    tick();
    reg_wr = 1'b0;
    if (s == 3'd7) chk({tag, " R10 wr"}, {vram_we, vram_wa, vram_wd}, {1'b1, wa, d});
    if (s == 3'd4) chk({tag, " R11 wr"}, {spr_we, spr_wa, spr_wd}, {1'b1, sa, d});
    chk_state(tag);
  endtask

  task automatic do_rd(input logic [2:0] s, input logic [7:0] vq, input bit cd,
                       input string tag);
    logic [7:0] exp;
    exp = 8'h00;
    reg_sel = s; vram_q = vq; reg_rd = 1'b1;
    if (s == 3'd2) begin
      exp = {m_vbl, 7'd0}; m_vbl = 1'b0; m_tog = 1'b0;
    end else if (s == 3'd7) begin
      exp = m_buf; m_buf = vq; m_vaddr = m_vaddr + step_of(m_ctrl);
    end
    tick();
    reg_rd = 1'b0;
    if (cd) chk({tag, " R7/R10 rd"}, reg_rdata, exp);
    chk_state(tag);
  endtask

  task automatic do_dma(input logic [7:0] d);
    logic [7:0] sa;
    sa = m_spra;
    dma_we = 1'b1; dma_wd = d;
    m_spra = m_spra + 8'd1;
    tick();
    dma_we = 1'b0;
    chk("R11 dma", {spr_we, spr_wa, spr_wd}, {1'b1, sa, d});
    chk_state("R11 dma state");
  endtask

  task automatic rand_op(input string tag);
    int r;
    logic [2:0] s;
    logic [7:0] d;
    r = $urandom_range(0, 9);
    s = 3'($urandom_range(0, 7));
    d = 8'($urandom);
    if (r < 6)      do_wr(s, d, tag);
    else if (r < 9) do_rd(s, 8'($urandom), 1'b1, tag);
    else            do_dma(d);
  endtask

  initial begin
    void'($urandom(32'h1234_5EED));
    // R1: cold power-on
    boot(1'b1, 1'b0, 1'b0);
    chk_state("R1 cold state");
    chk("R1 rdata", reg_rdata, 8'h00);
    do_rd(3'd7, 8'h3C, 1'b0, "R5 prime buffer");
    // R5: ungated offsets work at once; R4 gated ones dropped
    do_wr(3'd3, 8'h5A, "R5 spr ptr");
    do_wr(3'd4, 8'h11, "R5 spr data");
    do_wr(3'd0, 8'hFF, "R4 early ctrl");
    do_wr(3'd6, 8'h21, "R4 early addr");
    do_rd(3'd2, 8'h00, 1'b1, "R5 status");
    for (int i = 0; i < 60; i++) rand_op("R4/R5 gated rand");
    // R6: first vertical blank
    idle_to(VF - 1);
    chk("R6 before first", vblank_o, 1'b0);
    tick();
    chk("R6 first set", vblank_o, 1'b1);
    // R4: window boundary
    idle_to(WARM - 2);
    do_wr(3'd0, 8'h04, "R4 edge WARM-1 dropped");
    do_wr(3'd0, 8'h04, "R4 edge WARM accepted");
    chk("R4 ctrl value", ctrl_o, 8'h04);
    // R8/R9/R10/R11 random traffic with gate open
    for (int i = 0; i < 200; i++) rand_op("R8/R9/R10/R11 rand");
    do_rd(3'd2, 8'h00, 1'b1, "R7 clear");
    do_wr(3'd5, 8'h12, "R8 scroll lo");
    do_rd(3'd2, 8'h00, 1'b1, "R7 toggle clr");
    do_wr(3'd5, 8'h34, "R8 scroll lo again");
    do_wr(3'd5, 8'h56, "R8 scroll hi");
    chk("R8 scroll", scroll_o, 16'h5634);
    // R6/R7: periodic set coinciding with a status read
    idle_to(VF + VP - 1);
    chk("R6 before second", vblank_o, 1'b0);
    do_rd(3'd2, 8'h00, 1'b1, "R7 read on set edge");
    chk("R6 second set", vblank_o, 1'b1);
    // prepare non-zero state for the warm reset
    do_wr(3'd0, 8'hA5, "R2 prep ctrl");
    do_wr(3'd1, 8'hFF, "R2 prep mask");
    do_wr(3'd3, 8'h77, "R2 prep spr");
    do_wr(3'd6, 8'h2B, "R9 addr hi");
    do_wr(3'd6, 8'hCD, "R9 addr lo");
    chk("R9 addr", vaddr_o, 16'h2BCD);
    do_rd(3'd7, 8'hE1, 1'b1, "R10 load buf");
    do_wr(3'd5, 8'h99, "R2 prep toggle");
    // R2: warm reset
    boot(1'b0, 1'b0, 1'b1);
    chk_state("R2 warm state");
    chk("R2 mask", mask_o, 8'h06);
    do_rd(3'd7, 8'h42, 1'b1, "R2 buffer zero");
    do_wr(3'd0, 8'h80, "R4 after reset");
    idle_to(WARM - 2);
    do_wr(3'd1, 8'h18, "R4 reset edge WARM-1");
    do_wr(3'd1, 8'h18, "R4 reset edge WARM");
    do_wr(3'd6, 8'h3F, "R2/R9 toggle cleared hi");
    do_wr(3'd6, 8'h10, "R9 lo");
    chk("R9 addr after reset", vaddr_o, 16'h3F10);
    // R3: power restored after brief outage
    boot(1'b1, 1'b1, 1'b0);
    chk_state("R3 brief state");
    chk("R3 vaddr", vaddr_o, 16'h0001);
    do_wr(3'd0, 8'h33, "R3 gated ctrl");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R6 act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule